// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block decides, cycle by cycle, which clocks a small microcontroller-based modem core may receive. It runs on the free-running oscillator clock and produces two clock enables: one that feeds the processor core and one that feeds the serial port, timers and interrupt logic. In the run state both are on. In standby only the processor enable is withdrawn, so instruction fetch and internal bus traffic stop while the serial port, timers and interrupt logic keep running. In power-down both enables are off.

Standby is entered automatically. Firmware must have enabled the option, the line must be on hook, and a programmable number of oscillator cycles must pass with no host-activity strobe. Any of three external wake lines ends standby: the terminal-ready line, the ring-detect line, and the line that follows the host's serial transmit data. Each line is first passed through two flops. A rising edge counts as a wake event. Power-down is requested by firmware through a request input, which may also be driven from terminal-ready handling. Only a rising edge on the terminal-ready line or a reset ends power-down.

The reset input is active high and asserts asynchronously. Inside the block, reset is released synchronously. Both clock enables are updated on the falling clock edge. An external AND-type gate can therefore combine them with the clock without producing a glitch.

Top module: `cpu_standby_gate`

## Requirements
- R1: While reset is held and after it is released, the state output reads 00 (run) and both clock enables read 1.
- R2: In run, with standby enabled, on hook and no host strobe, with limit L on `idle_lim`, the state becomes 01 at the (L+1)-th rising clock edge after the edge at which the last host strobe was sampled. It is still 00 one edge earlier.
- R3: If standby is disabled or the line is off hook, the block stays in run (00) regardless of how long no host strobe arrives.
- R4: A host strobe restarts the idle count, so standby is reached L+1 edges after the latest strobe and not after the first one.
- R5: In standby (01), the processor clock enable is 0 and the peripheral clock enable is 1.
- R6: In standby, a rising edge on any one of the three wake lines returns the state to 00 at the third rising clock edge after the line rises. The processor enable returns to 1 at the falling edge that follows.
- R7: In standby, the power-down request, the host strobe, and changes to the standby-enable or on-hook inputs have no effect. The state stays 01 and the processor enable stays 0.
- R8: In run, a power-down request sampled at a rising edge moves the state to 10 at that edge, even when the idle timeout expires in the same cycle. In 10 both clock enables are 0. The value 11 never appears.
- R9: In power-down, rising edges on the ring-detect or host-data wake lines are ignored. A rising edge on the terminal-ready line returns the state to 00 at the third rising edge after the line rises.
- R10: Both clock enables change only at falling clock edges. After a state change at a rising edge, the enables still show their old values until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Active-high reset, asynchronous assertion |
| wake_dte_rdy | input | 1 | Terminal-ready wake line, asynchronous |
| wake_ring_det | input | 1 | Ring-detect wake line, asynchronous |
| wake_host_char | input | 1 | Wake line following host transmit data, asynchronous |
| on_hook | input | 1 | 1 when the line is on hook |
| host_act | input | 1 | One-cycle strobe on each host command activity |
| stby_en | input | 1 | 1 enables automatic standby |
| pd_req | input | 1 | Power-down request from firmware |
| idle_lim | input | CNT_W | Idle timeout limit L, in oscillator cycles |
| cpu_clk_en | output | 1 | Processor clock enable, updated on the falling edge |
| per_clk_en | output | 1 | Peripheral clock enable, updated on the falling edge |
| pm_state | output | 2 | 00 run, 01 standby, 10 power-down |

## Verification
The idle timeout is swept over every limit from 0 to 5. For each limit the bench checks the exact edge at which standby is entered, which separates off-by-one errors in the counter compare from errors in the strobe clear. A second sweep retriggers the strobe midway through the count, which shows whether the count restarts or only pauses. Every wake line is raised in standby and again in power-down. This separates the lines that wake both states from the lines that must be ignored in power-down, and the sampled latency confirms the depth of the synchronizer. The enables are also read just after a state-changing rising edge and again after the falling edge, which shows that they are updated on the falling edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_STBY = 2'b01,
    PM_PDN  = 2'b10
  } pm_state_e;

  localparam int unsigned N_WAKE   = 3;
  localparam int unsigned WK_DTE   = 0;
  localparam int unsigned WK_RING  = 1;
  localparam int unsigned WK_HCHAR = 2;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic [STAGES-1:0] sync_q;
      logic              prev_q;
      logic              sync_d;

      assign sync_d = sync_q[STAGES-1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[STAGES-2:0], line_i[g]};
          prev_q <= sync_d;
        end
      end

      assign rise_o[g] = sync_d & ~prev_q;

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[g] |=> !rise_o[g]) else $error("rise pulse longer than one cycle"); // R6
    end
  endgenerate

endmodule

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             stby_en_i,
  input  logic             on_hook_i,
  input  logic             host_act_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tmo_o
);

  logic             qualify;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign qualify = run_i & stby_en_i & on_hook_i & ~host_act_i;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!qualify) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q < lim_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tmo_o = qualify & (cnt_q >= lim_i);

  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    host_act_i |=> (cnt_q == '0)) else $error("strobe did not clear count"); // R4
  AST_NO_TMO_OFFHOOK: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_hook_i || !stby_en_i) |-> !tmo_o) else $error("timeout without permission"); // R3

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_i,
  input  logic              pd_req_i,
  input  logic [N_WAKE-1:0] rise_i,
  output pm_state_e         state_o
);

  pm_state_e st_q;
  pm_state_e st_d;
  logic      wake_any;
  logic      dte_rise;

  assign wake_any = |rise_i;
  assign dte_rise = rise_i[WK_DTE];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PM_RUN: begin
        if (pd_req_i)   st_d = PM_PDN;
        else if (tmo_i) st_d = PM_STBY;
      end
      PM_STBY: begin
        if (wake_any) st_d = PM_RUN;
      end
      PM_PDN: begin
        if (dte_rise) st_d = PM_RUN;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PM_RUN;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != pm_state_e'(2'b11)) else $error("illegal state"); // R8
  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && pd_req_i) |=> (st_q == PM_PDN)) else $error("power-down not entered"); // R8
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_STBY && !wake_any) |=> (st_q == PM_STBY)) else $error("standby left without wake"); // R7
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_PDN && !dte_rise) |=> (st_q == PM_PDN)) else $error("power-down left without terminal-ready"); // R9
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_STBY && wake_any) |=> (st_q == PM_RUN)) else $error("wake ignored"); // R6

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_i,
  output logic      cpu_en_o,
  output logic      per_en_o
);

  logic cpu_en_d;
  logic per_en_d;
  logic cpu_en_q;
  logic per_en_q;

  always_comb begin
    cpu_en_d = (state_i == PM_RUN);
    per_en_d = (state_i != PM_PDN);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b1;
      per_en_q <= 1'b1;
    end else begin
      cpu_en_q <= cpu_en_d;
      per_en_q <= per_en_d;
    end
  end

  assign cpu_en_o = cpu_en_q;
  assign per_en_o = per_en_q;

  AST_PD_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en_q |-> !cpu_en_q) else $error("core clocked while peripherals stopped"); // R8
  AST_STBY_CPU_OFF: assert property (@(negedge clk) disable iff (!rst_n)
    (state_i == PM_STBY) |=> !cpu_en_q) else $error("core clock on in standby"); // R5
  AST_STBY_PER_ON: assert property (@(negedge clk) disable iff (!rst_n)
    (state_i == PM_STBY) |=> per_en_q) else $error("peripheral clock off in standby"); // R5

endmodule

// File: rtl/cpu_standby_gate.sv
module cpu_standby_gate
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk_osc,
  input  logic             rst,
  input  logic             wake_dte_rdy,
  input  logic             wake_ring_det,
  input  logic             wake_host_char,
  input  logic             on_hook,
  input  logic             host_act,
  input  logic             stby_en,
  input  logic             pd_req,
  input  logic [CNT_W-1:0] idle_lim,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [1:0]       pm_state
);

  logic              rst_n;
  logic [N_WAKE-1:0] wake_lines;
  logic [N_WAKE-1:0] wake_rise;
  logic              tmo;
  pm_state_e         state;

  always_comb begin
    wake_lines           = '0;
    wake_lines[WK_DTE]   = wake_dte_rdy;
    wake_lines[WK_RING]  = wake_ring_det;
    wake_lines[WK_HCHAR] = wake_host_char;
  end

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk_osc),
    .rst_i   (rst),
    .rst_n_o (rst_n)
  );

  pmc_wake_sync #(.N(N_WAKE), .STAGES(SYNC_DEPTH)) u_wake (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .line_i (wake_lines),
    .rise_o (wake_rise)
  );

  pmc_idle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .run_i      (state == PM_RUN),
    .stby_en_i  (stby_en),
    .on_hook_i  (on_hook),
    .host_act_i (host_act),
    .lim_i      (idle_lim),
    .tmo_o      (tmo)
  );

  pmc_fsm u_fsm (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .tmo_i    (tmo),
    .pd_req_i (pd_req),
    .rise_i   (wake_rise),
    .state_o  (state)
  );

  pmc_clk_gate u_gate (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .state_i  (state),
    .cpu_en_o (cpu_clk_en),
    .per_en_o (per_clk_en)
  );

  assign pm_state = state;

  AST_RUN_NEEDS_PERMIT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (pm_state == 2'b00 && !pd_req && !(stby_en && on_hook)) |=> (pm_state == 2'b00))
    else $error("run left without permission"); // R3

endmodule

// File: tb/sim_cpu_standby_gate.sv
`timescale 1ns/1ps
module sim_cpu_standby_gate;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          w_dte, w_ring, w_hc;
  logic          on_hook, host_act, stby_en, pd_req;
  logic [CW-1:0] idle_lim;
  logic          cpu_en, per_en;
  logic [1:0]    st;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cpu_standby_gate #(.CNT_W(CW)) u0 (
    .clk_osc(clk), .rst(rst),
    .wake_dte_rdy(w_dte), .wake_ring_det(w_ring), .wake_host_char(w_hc),
    .on_hook(on_hook), .host_act(host_act), .stby_en(stby_en), .pd_req(pd_req),
    .idle_lim(idle_lim), .cpu_clk_en(cpu_en), .per_clk_en(per_en), .pm_state(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic go_standby();
    idle_lim = CW'(2);
    stby_en  = 1'b1;
    on_hook  = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (st == 2'b01) break;
      adv(1);
    end
    stby_en = 1'b0;
  endtask

  task automatic set_wake(input int idx, input logic v);
    case (idx)
      0: w_dte  = v;
      1: w_ring = v;
      default: w_hc = v;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; w_dte = 0; w_ring = 0; w_hc = 0;
    on_hook = 1; host_act = 0; stby_en = 0; pd_req = 0; idle_lim = '0;
    adv(3);
    #13;
    chk("R1 state in reset", st, 0);
    chk("R1 cpu_en in reset", cpu_en, 1);
    chk("R1 per_en in reset", per_en, 1);
    adv(1);
    rst = 1'b0;
    adv(4);
    #13;
    chk("R1 state after reset", st, 0);
    chk("R1 cpu_en after reset", cpu_en, 1);
    chk("R1 per_en after reset", per_en, 1);

    // R2: exhaustive sweep of small limits
    for (int lim = 0; lim <= 5; lim++) begin
      adv(1);
      idle_lim = CW'(lim); stby_en = 1; on_hook = 1; host_act = 1;
      adv(1);
      host_act = 0;
      adv(lim);
      #13 chk($sformatf("R2 still run lim=%0d", lim), st, 0);
      adv(1);
      #13 chk($sformatf("R2 standby lim=%0d", lim), st, 1);
      chk("R5 cpu_en in standby", cpu_en, 0);
      chk("R5 per_en in standby", per_en, 1);
      stby_en = 0;
      adv(1);
      w_hc = 1;
      adv(3);
      #13 chk("R6 woken by host data line", st, 0);
      w_hc = 0;
      adv(2);
    end

    // R4: retrigger mid-count
    for (int k = 1; k <= 3; k++) begin
      adv(1);
      idle_lim = CW'(4); stby_en = 1; on_hook = 1; host_act = 1;
      adv(1);
      host_act = 0;
      adv(k);
      host_act = 1;
      adv(1);
      host_act = 0;
      adv(4);
      #13 chk($sformatf("R4 run after retrigger k=%0d", k), st, 0);
      adv(1);
      #13 chk($sformatf("R4 standby after retrigger k=%0d", k), st, 1);
      stby_en = 0;
      w_ring = 1;
      adv(4);
      w_ring = 0;
      adv(2);
    end

    // R3: permission missing
    for (int c = 0; c < 3; c++) begin
      idle_lim = CW'(1);
      stby_en  = (c == 1);
      on_hook  = (c == 2);
      adv(20);
      #13 chk($sformatf("R3 stays run case=%0d", c), st, 0);
      adv(1);
    end
    on_hook = 1; stby_en = 0;

    // R6 / R10: each wake line from standby, exact latency
    for (int w = 0; w < 3; w++) begin
      go_standby();
      adv(1);
      set_wake(w, 1'b1);
      adv(2);
      #13 chk($sformatf("R6 not yet awake line=%0d", w), st, 1);
      adv(1);
      #3 chk($sformatf("R10 cpu_en held before falling edge line=%0d", w), cpu_en, 0);
      chk($sformatf("R6 awake line=%0d", w), st, 0);
      #10 chk($sformatf("R6 cpu_en after wake line=%0d", w), cpu_en, 1);
      set_wake(w, 1'b0);
      adv(3);
    end

    // R7: ignored stimulus in standby
    go_standby();
    pd_req = 1; host_act = 1; stby_en = 1; on_hook = 0;
    adv(1);
    pd_req = 0; host_act = 0; on_hook = 1; stby_en = 0;
    adv(5);
    #13 chk("R7 state held in standby", st, 1);
    chk("R7 cpu_en held off", cpu_en, 0);
    chk("R7 per_en held on", per_en, 1);
    w_dte = 1;
    adv(4);
    w_dte = 0;
    adv(2);

    // R8: power-down, with simultaneous timeout
    idle_lim = '0; stby_en = 1; on_hook = 1; pd_req = 1;
    adv(1);
    pd_req = 0; stby_en = 0;
    #3 chk("R8 state power-down", st, 2);
    chk("R10 per_en held before falling edge", per_en, 1);
    #10 chk("R8 cpu_en off", cpu_en, 0);
    chk("R8 per_en off", per_en, 0);

    // R9: only terminal-ready leaves power-down
    w_ring = 1; w_hc = 1;
    adv(6);
    #13 chk("R9 ring/host lines ignored", st, 2);
    chk("R9 per_en still off", per_en, 0);
    w_ring = 0; w_hc = 0;
    adv(1);
    w_dte = 1;
    adv(2);
    #13 chk("R9 not yet awake", st, 2);
    adv(1);
    #13 chk("R9 terminal-ready wakes", st, 0);
    chk("R9 per_en restored", per_en, 1);
    chk("R9 cpu_en restored", cpu_en, 1);
    w_dte = 0;
    adv(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule